// File: doc/BRIEF.md
# Uplink Load-Modulation Framer

This block turns a response word into the single load-modulation control line that a passive tag uses to answer a reader. On a `start` request it captures a data word, the number of bits to send, a line-coding select, a rate divisor and a preamble length. It then plays out a start-of-frame pattern followed by the data, most significant bit first. The bit period is a whole number of field clocks set by the rate divisor. All internal timing is counted in half-bit periods of `rate_n + 1` field clocks.

The start-of-frame pattern has three parts: a run of Manchester-coded zeros as preamble, a two-bit code violation, and half a bit of unmodulated carrier. The data that follows is Manchester, bi-phase or direct NRZ coded, as the coding select requests. `busy` covers the whole frame. `done` marks its end with a one-cycle pulse. The output rests low whenever no frame is in progress.

Top module: `uplink_framer`

## Requirements
- R1: After reset, and whenever no frame is in progress, `mod_on`, `busy` and `done` are low.
- R2: Each half-bit lasts `rate_n + 1` field clocks, so a full bit lasts `2*(rate_n+1)` clocks. The first half-bit occupies the `rate_n + 1` cycles that follow the clock edge that accepts `start`.
- R3: The frame opens with `preamble_len` Manchester zeros. Each zero is one half-bit with modulation on, then one half-bit with modulation off.
- R4: A `preamble_len` of 0 sends exactly one start bit, which is a single Manchester zero, before the code violation.
- R5: After the preamble come two half-bits with modulation on, then two half-bits with modulation off (the code violation), then one half-bit with modulation off.
- R6: With `coding` = 0 (Manchester), a data 0 is on then off, giving a falling mid-bit edge. A data 1 is off then on, giving a rising edge.
- R7: With `coding` = 1 (bi-phase), the level inverts at every bit boundary. The first data half-bit is on, because it inverts the off half-bit before it. A data 0 also inverts at mid-bit; a data 1 holds its level for the whole bit.
- R8: With `coding` = 2 or 3 (NRZ), a data 1 is modulation off for the whole bit, and a data 0 is modulation on.
- R9: The data bits sent are `data_word[bit_count-1]` down to `data_word[0]`, in that order. A `bit_count` above `DATA_W` is treated as `DATA_W`. A `bit_count` of 0 ends the frame after the start-of-frame pattern.
- R10: `busy` rises in the cycle after `start` is accepted and stays high through the last half-bit. A `start` raised while `busy` is high is ignored.
- R11: In the cycle right after the last half-bit, `done` is high for exactly one clock, with `busy` and `mod_on` low.
- R12: Configuration and data are captured when `start` is accepted. Changing the inputs during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Field clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a frame; accepted when not busy |
| data_word | input | DATA_W | Data to send, right-aligned |
| bit_count | input | CNT_W | Number of data bits (clamped to DATA_W) |
| coding | input | 2 | 0 Manchester, 1 bi-phase, 2/3 NRZ |
| rate_n | input | RATE_W | Half-bit length minus one, in field clocks |
| preamble_len | input | PRE_W | Number of preamble zeros (0 means one) |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| mod_on | output | 1 | Load modulation on |

## Verification
The bench goes after the boundary settings. With `rate_n` at 0, every half-bit is a single clock; a half-bit counter that is off by one would then double or drop levels. With a zero preamble, a design that treats zero literally skips the start bit and moves the code violation two half-bits early. In bi-phase, the first data bit must invert the quiet half-bit before it, and a coder that tracks the wrong previous level flips every bit of the data. The bench also covers a `bit_count` of 0 and one above the word width, and inputs that change in mid-frame along with a retriggering `start`. A design that latches late or re-arms on `start` would bend the waveform, or fire `done` at the wrong time.

// File: rtl/uplink_pkg.sv
package uplink_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_PRE  = 3'd1,
    PH_CV   = 3'd2,
    PH_GAP  = 3'd3,
    PH_DATA = 3'd4
  } phase_t;

  typedef enum logic [1:0] {
    LC_MANCH   = 2'd0,
    LC_BIPHASE = 2'd1,
    LC_NRZ     = 2'd2,
    LC_NRZ_ALT = 2'd3
  } linecode_t;

  // Level of one data half-bit; prev is the level of the half-bit before it.
  function automatic logic data_half_level(linecode_t lc, logic bitv,
                                           logic second, logic prev);
    logic lvl;
    case (lc)
      LC_MANCH:   lvl = second ? bitv : ~bitv;
      LC_BIPHASE: lvl = second ? (prev ^ ~bitv) : ~prev;
      default:    lvl = ~bitv;
    endcase
    return lvl;
  endfunction

  // Level of one start-of-frame half-bit, hidx counted within its phase.
  function automatic logic sof_half_level(phase_t ph, logic [1:0] hidx);
    logic lvl;
    case (ph)
      PH_PRE:  lvl = ~hidx[0];
      PH_CV:   lvl = ~hidx[1];
      default: lvl = 1'b0;
    endcase
    return lvl;
  endfunction

  // Index of the final preamble half-bit: 2*max(len,1) - 1.
  function automatic int unsigned pre_last_half(int unsigned len);
    int unsigned eff;
    eff = (len == 0) ? 1 : len;
    return 2 * eff - 1;
  endfunction

endpackage

// File: rtl/uplink_halfbit_timer.sv
module uplink_halfbit_timer #(
  parameter int RATE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              run,
  input  logic [RATE_W-1:0] limit,
  output logic              tick
);
  logic [RATE_W-1:0] cnt;

  assign tick = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (run) begin
      if (cnt == limit) cnt <= '0;
      else              cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/uplink_bit_shifter.sv
module uplink_bit_shifter #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  input  logic [CNT_W-1:0]  count,
  input  logic              advance,
  output logic              cur_bit,
  output logic [CNT_W-1:0]  bits_left
);
  localparam logic [CNT_W-1:0] MAXC = CNT_W'(DATA_W);

  logic [DATA_W-1:0] sh;
  logic [CNT_W-1:0]  n_cl;

  assign n_cl    = (count > MAXC) ? MAXC : count;
  assign cur_bit = sh[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh        <= '0;
      bits_left <= '0;
    end else if (load) begin
      sh        <= data << (MAXC - n_cl);
      bits_left <= n_cl;
    end else if (advance) begin
      sh        <= {sh[DATA_W-2:0], 1'b0};
      bits_left <= bits_left - 1'b1;
    end
  end
endmodule

// File: rtl/uplink_line_coder.sv
module uplink_line_coder
  import uplink_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       tick,
  input  phase_t     phase,
  input  logic [1:0] hidx,
  input  logic       cur_bit,
  input  linecode_t  lc,
  output logic       level
);
  logic prev_lvl;

  always_comb begin
    if (phase == PH_DATA) level = data_half_level(lc, cur_bit, hidx[0], prev_lvl);
    else                  level = sof_half_level(phase, hidx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     prev_lvl <= 1'b0;
    else if (clear) prev_lvl <= 1'b0;
    else if (tick)  prev_lvl <= level;
  end
endmodule

// File: rtl/uplink_framer.sv
module uplink_framer
  import uplink_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int RATE_W = 5,
  parameter int PRE_W  = 4,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] data_word,
  input  logic [CNT_W-1:0]  bit_count,
  input  logic [1:0]        coding,
  input  logic [RATE_W-1:0] rate_n,
  input  logic [PRE_W-1:0]  preamble_len,
  output logic              busy,
  output logic              done,
  output logic              mod_on
);
  localparam int HC_W = (PRE_W + 1 < 2) ? 2 : PRE_W + 1;

  phase_t            phase;
  logic [HC_W-1:0]   hcnt;
  logic [HC_W-1:0]   pre_last_q;
  logic [RATE_W-1:0] rate_q;
  linecode_t         lc_q;
  logic              load;
  logic              half_tick;
  logic              bit_advance;
  logic              cur_bit;
  logic [CNT_W-1:0]  bits_left;
  logic              frame_end;

  assign load        = start && (phase == PH_IDLE);
  assign busy        = (phase != PH_IDLE);
  assign bit_advance = half_tick && (phase == PH_DATA) && hcnt[0];
  assign frame_end   = half_tick &&
                       (((phase == PH_GAP) && (bits_left == '0)) ||
                        ((phase == PH_DATA) && hcnt[0] && (bits_left == CNT_W'(1))));

  uplink_halfbit_timer #(.RATE_W(RATE_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (load),
    .run   (busy),
    .limit (rate_q),
    .tick  (half_tick)
  );

  uplink_bit_shifter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .data      (data_word),
    .count     (bit_count),
    .advance   (bit_advance),
    .cur_bit   (cur_bit),
    .bits_left (bits_left)
  );

  uplink_line_coder u_coder (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (load),
    .tick    (half_tick),
    .phase   (phase),
    .hidx    (hcnt[1:0]),
    .cur_bit (cur_bit),
    .lc      (lc_q),
    .level   (mod_on)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      hcnt       <= '0;
      pre_last_q <= '0;
      rate_q     <= '0;
      lc_q       <= LC_MANCH;
      done       <= 1'b0;
    end else if (load) begin
      phase      <= PH_PRE;
      hcnt       <= '0;
      pre_last_q <= HC_W'(pre_last_half(int'(preamble_len)));
      rate_q     <= rate_n;
      lc_q       <= linecode_t'(coding);
      done       <= 1'b0;
    end else begin
      done <= frame_end;
      if (half_tick) begin
        case (phase)
          PH_PRE: begin
            if (hcnt == pre_last_q) begin
              phase <= PH_CV;
              hcnt  <= '0;
            end else begin
              hcnt <= hcnt + 1'b1;
            end
          end
          PH_CV: begin
            if (hcnt[1:0] == 2'd3) begin
              phase <= PH_GAP;
              hcnt  <= '0;
            end else begin
              hcnt <= hcnt + 1'b1;
            end
          end
          PH_GAP: begin
            phase <= frame_end ? PH_IDLE : PH_DATA;
            hcnt  <= '0;
          end
          PH_DATA: begin
            if (frame_end) phase <= PH_IDLE;
            hcnt <= {{(HC_W-1){1'b0}}, ~hcnt[0]};
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uplink_framer_chk.sv
module uplink_framer_chk
  import uplink_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   start,
  input logic   busy,
  input logic   done,
  input logic   mod_on,
  input logic   half_tick,
  input phase_t phase
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mod_on);

  assert_level_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(half_tick)) |-> $stable(mod_on));

  assert_gap_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_GAP) |-> !mod_on);

  assert_restart_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !half_tick) |=> busy);

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_at_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($fell(busy) && !mod_on));
endmodule

bind uplink_framer uplink_framer_chk u_chk (.*);

// File: tb/uplink_framer_test.sv
module uplink_framer_test;
  localparam int DATA_W = 32;
  localparam int RATE_W = 5;
  localparam int PRE_W  = 4;
  localparam int CNT_W  = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [DATA_W-1:0] data_word = '0;
  logic [CNT_W-1:0]  bit_count = '0;
  logic [1:0]        coding = '0;
  logic [RATE_W-1:0] rate_n = '0;
  logic [PRE_W-1:0]  preamble_len = '0;
  logic              busy, done, mod_on;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit reported = 0;

  logic exp_h [0:127];
  int   nh;
  int   n_pre_halves;

  uplink_framer #(.DATA_W(DATA_W), .RATE_W(RATE_W), .PRE_W(PRE_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .data_word(data_word),
    .bit_count(bit_count), .coding(coding), .rate_n(rate_n),
    .preamble_len(preamble_len), .busy(busy), .done(done), .mod_on(mod_on)
  );

  always #4 clk = ~clk;

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      failures++;
      $display("FAIL watchdog: actual=expired expected=finished");
      report();
    end
  end

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic push(logic v);
    exp_h[nh] = v;
    nh++;
  endtask

  // Expected half-bit sequence for one frame, from the requirements.
  task automatic build(logic [DATA_W-1:0] d, int bc, int lc, int pl);
    int   p;
    int   nb;
    logic last;
    logic f;
    nh = 0;
    p  = (pl == 0) ? 1 : pl;               // R4
    for (int i = 0; i < p; i++) begin push(1); push(0); end  // R3
    n_pre_halves = nh;
    push(1); push(1); push(0); push(0); push(0);             // R5
    nb = (bc > DATA_W) ? DATA_W : bc;      // R9
    last = 1'b0;
    for (int b = nb - 1; b >= 0; b--) begin
      case (lc)
        0: begin push(~d[b]); push(d[b]); end                // R6
        1: begin f = ~last; push(f); push(f ^ ~d[b]); end    // R7
        default: begin push(~d[b]); push(~d[b]); end         // R8
      endcase
      last = exp_h[nh-1];
    end
  endtask

  function automatic string tag_for(int k, int lc);
    if (k < n_pre_halves) return "R2 R3 R4";
    if (k < n_pre_halves + 5) return "R2 R5";
    if (lc == 0) return "R2 R6 R9";
    if (lc == 1) return "R2 R7 R9";
    return "R2 R8 R9";
  endfunction

  // Run one frame; pert_c > 0 perturbs inputs and re-pulses start then (R10, R12).
  task automatic run_frame(logic [DATA_W-1:0] d, int bc, int lc, int rn, int pl, int pert_c);
    int  per;
    int  total;
    int  k;
    bit  wave_ok;
    bit  busy_ok;
    int  bad_k;
    int  bad_a;
    build(d, bc, lc, pl);
    per   = rn + 1;
    total = nh * per;
    @(negedge clk);
    data_word = d; bit_count = CNT_W'(bc); coding = 2'(lc);
    rate_n = RATE_W'(rn); preamble_len = PRE_W'(pl); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wave_ok = 1; busy_ok = 1; bad_k = 0; bad_a = 0;
    for (int c = 1; c <= total; c++) begin
      k = (c - 1) / per;
      if (wave_ok && (mod_on !== exp_h[k])) begin
        wave_ok = 0; bad_k = k; bad_a = int'(mod_on);
      end
      if (busy !== 1'b1 || done !== 1'b0) busy_ok = 0;
      start = 1'b0;
      if (c == pert_c) begin
        data_word = ~d; bit_count = CNT_W'($urandom_range(0, 40));
        coding = 2'($urandom_range(0, 3)); rate_n = RATE_W'($urandom_range(0, 31));
        preamble_len = PRE_W'($urandom_range(0, 15)); start = 1'b1;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(wave_ok, (pert_c > 0) ? "R12" : tag_for(bad_k, lc),
          $sformatf("mod_on at half-bit %0d", bad_k), bad_a, wave_ok ? bad_a : int'(exp_h[bad_k]));
    check(busy_ok, "R10", "busy held through frame", busy_ok, 1);
    check(done === 1'b1 && busy === 1'b0 && mod_on === 1'b0, "R11",
          "done/busy/mod_on after last half", {done, busy, mod_on}, 3'b100);
    @(negedge clk);
    check(done === 1'b0 && mod_on === 1'b0, "R11 R1", "done/mod_on one cycle later",
          {done, mod_on}, 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check(mod_on === 1'b0 && busy === 1'b0 && done === 1'b0, "R1",
          "outputs in reset", {mod_on, busy, done}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(mod_on === 1'b0 && busy === 1'b0, "R1", "outputs idle", {mod_on, busy}, 0);

    // Directed corner cases
    run_frame(32'hA5, 8, 0, 0, 0, 0);                 // R2 R4 R6: one-clock half-bits
    run_frame(32'h0000_00F0, 8, 1, 3, 2, 0);          // R7 bi-phase
    run_frame(32'hDEAD_BEEF, 32, 2, 31, 15, 0);       // R8 slowest rate, longest preamble
    run_frame(32'h1234_5678, 16, 3, 1, 1, 0);         // R8 alternate NRZ code
    run_frame(32'hFFFF_FFFF, 0, 0, 2, 3, 0);          // R9 no data bits
    run_frame(32'h8000_0001, 40, 1, 0, 4, 0);         // R9 count clamp
    run_frame(32'h0000_0000, 5, 1, 2, 0, 0);          // R7 all zeros
    run_frame(32'h0000_0006, 3, 0, 4, 2, 30);         // R10 R12 mid-frame changes

    // Random frames
    for (int i = 0; i < 24; i++) begin
      run_frame($urandom, $urandom_range(0, 34), $urandom_range(0, 3),
                $urandom_range(0, 31), $urandom_range(0, 15),
                (i % 3 == 0) ? 9 : 0);
    end
    report();
  end
endmodule